// File: doc/BRIEF.md
# Packed SIMD ALU with Saturation

This block is a 64-bit arithmetic unit that treats each operand as a row of independent fields. A size code selects eight byte fields, four halfword fields or two word fields. Within each field it adds or subtracts, shifts, applies bitwise logic or compares. The add and subtract operations can wrap, or they can clamp to the signed or unsigned limits of the field. Compares write an all-ones or all-zeros mask into each field, so later code can select data without branching. Two further operations ignore the field split in part: a halfword multiply that keeps the low half of each product, and a pack that halves the width of every field of both operands and clamps any value that no longer fits.

A request is presented with `in_valid` high, together with the opcode, size, saturation mode, both operands and a shift count. The result is registered. It appears on the next clock edge with `out_valid` high and stays unchanged until the next accepted request.

Top module: `simd_alu`

## Requirements
- R1: Size code 0 selects 8-bit fields, 1 selects 16-bit fields and 2 selects 32-bit fields. With saturation mode 0 (or 3), add (op 0) and subtract (op 1) wrap modulo the field width, and no carry or borrow passes into the neighbouring field.
- R2: With saturation mode 1, add and subtract treat fields as two's-complement values. A result above the field's most positive value gives that value, and a result below the most negative value gives that value.
- R3: With saturation mode 2, add and subtract treat fields as unsigned values. A sum that overflows gives all ones in that field, and a difference that would be negative gives zero.
- R4: Op 2 shifts each field left and op 3 shifts each field right, both filling with zeros. Op 4 shifts each field right and fills with the field's sign bit. All three use the 6-bit shift count. A count equal to or larger than the field width gives zero for ops 2 and 3, and gives a field filled with the sign bit for op 4.
- R5: Op 5 gives A AND B, op 6 gives (NOT A) AND B, op 7 gives A OR B and op 8 gives A XOR B. The size code does not change these results (0, 1 and 2 give the same value).
- R6: Op 9 sets each field to all ones when the A and B fields are equal, and to all zeros when they differ.
- R7: Op 10 sets each field to all ones when the A field is greater than the B field as a signed value, and to all zeros otherwise.
- R8: Op 11 multiplies the four 16-bit fields pairwise and keeps the low 16 bits of each product, whatever the size code is (0, 1 or 2).
- R9: Op 12 narrows every field of A and B to half its width. Size 1 narrows 16-bit fields to 8 bits, and size 2 narrows 32-bit fields to 16 bits. The results from A fill the lower 32 bits of the result in field order, and the results from B fill the upper 32 bits. The source is read as signed. Mode 1 clamps to the signed range of the narrow field, mode 2 clamps to 0 and the unsigned maximum, and modes 0 and 3 keep the low half.
- R10: After reset, `result` is zero and `out_valid` is low. A request accepted on a clock edge shows its result and `out_valid` high after that same edge. When `in_valid` is low, `out_valid` falls on the next edge and `result` keeps its value.
- R11: Size code 3, opcodes 13 to 15, and op 12 with size 0 all give a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| size | input | 2 | Field size code |
| sat | input | 2 | Saturation mode |
| a | input | 64 | Operand A |
| b | input | 64 | Operand B |
| shamt | input | 6 | Shift count |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Registered result |

## Verification
Add and subtract are driven with operand pairs in which fields sit at the signed and unsigned extremes next to small values. This separates a wrapped result from a clamped one, a signed clamp from an unsigned clamp, and a field-local carry from one that leaks into the next field. Shifts are tried with counts of zero, a middle count, the field width minus one, the field width and the largest count, and each count is tried with positive and negative fields. This shows where the zero fill and sign fill begin. Compares use operands that match in some fields and differ in others, and pack uses fields above, below and inside the narrow range for each saturation mode. Reserved codes and idle cycles are checked to show the result stays zero or keeps its value.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_SLL   = 4'd2,
        OP_SRL   = 4'd3,
        OP_SRA   = 4'd4,
        OP_AND   = 4'd5,
        OP_ANDN  = 4'd6,
        OP_OR    = 4'd7,
        OP_XOR   = 4'd8,
        OP_CMPEQ = 4'd9,
        OP_CMPGT = 4'd10,
        OP_MUL   = 4'd11,
        OP_PACK  = 4'd12
    } simd_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSV  = 2'd3
    } simd_size_e;

    typedef enum logic [1:0] {
        SAT_WRAP     = 2'd0,
        SAT_SIGNED   = 2'd1,
        SAT_UNSIGNED = 2'd2,
        SAT_RSV      = 2'd3
    } simd_sat_e;

endpackage

// File: rtl/simd_field_unit.sv
module simd_field_unit
    import simd_alu_pkg::*;
#(
    parameter int W       = 8,
    parameter int SHAMT_W = 6
) (
    input  simd_op_e           op,
    input  simd_sat_e          sat,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [W-1:0]       y
);

    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] UMAX = {W{1'b1}};

    logic [W:0]   sum_x;
    logic [W:0]   dif_x;
    logic         s_ovf_add;
    logic         s_ovf_sub;
    logic         sh_big;
    logic [W-1:0] add_y;
    logic [W-1:0] sub_y;
    logic [W-1:0] sll_y;
    logic [W-1:0] srl_y;
    logic [W-1:0] sra_y;

    assign sum_x     = {1'b0, a} + {1'b0, b};
    assign dif_x     = {1'b0, a} - {1'b0, b};
    assign s_ovf_add = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
    assign s_ovf_sub = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
    assign sh_big    = ({1'b0, shamt} >= (SHAMT_W+1)'(W));

    always_comb begin
        unique case (sat)
            SAT_SIGNED: begin
                add_y = s_ovf_add ? (a[W-1] ? SMIN : SMAX) : sum_x[W-1:0];
                sub_y = s_ovf_sub ? (a[W-1] ? SMIN : SMAX) : dif_x[W-1:0];
            end
            SAT_UNSIGNED: begin
                add_y = sum_x[W] ? UMAX : sum_x[W-1:0];
                sub_y = dif_x[W] ? '0   : dif_x[W-1:0];
            end
            default: begin
                add_y = sum_x[W-1:0];
                sub_y = dif_x[W-1:0];
            end
        endcase
    end

    always_comb begin
        if (sh_big) begin
            sll_y = '0;
            srl_y = '0;
            sra_y = {W{a[W-1]}};
        end else begin
            sll_y = a << shamt;
            srl_y = a >> shamt;
            sra_y = $signed(a) >>> shamt;
        end
    end

    always_comb begin
        unique case (op)
            OP_ADD:   y = add_y;
            OP_SUB:   y = sub_y;
            OP_SLL:   y = sll_y;
            OP_SRL:   y = srl_y;
            OP_SRA:   y = sra_y;
            OP_AND:   y = a & b;
            OP_ANDN:  y = ~a & b;
            OP_OR:    y = a | b;
            OP_XOR:   y = a ^ b;
            OP_CMPEQ: y = {W{a == b}};
            OP_CMPGT: y = {W{$signed(a) > $signed(b)}};
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/simd_narrow.sv
module simd_narrow
    import simd_alu_pkg::*;
#(
    parameter int SW = 16
) (
    input  simd_sat_e        sat,
    input  logic [SW-1:0]    x,
    output logic [SW/2-1:0]  y
);

    localparam int NW = SW / 2;

    localparam logic [NW-1:0] NSMAX = {1'b0, {(NW-1){1'b1}}};
    localparam logic [NW-1:0] NSMIN = {1'b1, {(NW-1){1'b0}}};
    localparam logic [NW-1:0] NUMAX = {NW{1'b1}};

    logic [NW:0] upper_s;
    logic        fits_s;
    logic        fits_u;

    assign upper_s = x[SW-1:NW-1];
    assign fits_s  = (&upper_s) || (~|upper_s);
    assign fits_u  = ~|x[SW-1:NW];

    always_comb begin
        unique case (sat)
            SAT_SIGNED:   y = fits_s ? x[NW-1:0] : (x[SW-1] ? NSMIN : NSMAX);
            SAT_UNSIGNED: y = x[SW-1] ? '0 : (fits_u ? x[NW-1:0] : NUMAX);
            default:      y = x[NW-1:0];
        endcase
    end

endmodule

// File: rtl/simd_pack.sv
module simd_pack
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  simd_size_e        size,
    input  simd_sat_e         sat,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    localparam int HALF    = DATA_W / 2;
    localparam int H_LANES = DATA_W / 16;
    localparam int W_LANES = DATA_W / 32;

    logic [DATA_W-1:0] from_half;
    logic [DATA_W-1:0] from_word;

    for (genvar i = 0; i < H_LANES; i++) begin : g_half
        simd_narrow #(.SW(16)) u_na (
            .sat (sat),
            .x   (a[i*16 +: 16]),
            .y   (from_half[i*8 +: 8])
        );
        simd_narrow #(.SW(16)) u_nb (
            .sat (sat),
            .x   (b[i*16 +: 16]),
            .y   (from_half[HALF + i*8 +: 8])
        );
    end

    for (genvar i = 0; i < W_LANES; i++) begin : g_word
        simd_narrow #(.SW(32)) u_na (
            .sat (sat),
            .x   (a[i*32 +: 32]),
            .y   (from_word[i*16 +: 16])
        );
        simd_narrow #(.SW(32)) u_nb (
            .sat (sat),
            .x   (b[i*32 +: 32]),
            .y   (from_word[HALF + i*16 +: 16])
        );
    end

    always_comb begin
        unique case (size)
            SZ_HALF: y = from_half;
            SZ_WORD: y = from_word;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_mul16.sv
module simd_mul16 #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    localparam int LANES = DATA_W / 16;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign y[i*16 +: 16] = a[i*16 +: 16] * b[i*16 +: 16];
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SHAMT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [3:0]         op,
    input  logic [1:0]         size,
    input  logic [1:0]         sat,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic [SHAMT_W-1:0] shamt,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result
);

    localparam int N_SIZES = 3;

    simd_op_e   op_e;
    simd_size_e size_e;
    simd_sat_e  sat_e;

    assign op_e   = simd_op_e'(op);
    assign size_e = simd_size_e'(size);
    assign sat_e  = simd_sat_e'(sat);

    logic [N_SIZES-1:0][DATA_W-1:0] lane_y;
    logic [DATA_W-1:0]              mul_y;
    logic [DATA_W-1:0]              pack_y;
    logic [DATA_W-1:0]              next_y;

    for (genvar gw = 0; gw < N_SIZES; gw++) begin : g_size
        localparam int W = 8 << gw;
        localparam int N = DATA_W / W;
        for (genvar i = 0; i < N; i++) begin : g_field
            simd_field_unit #(.W(W), .SHAMT_W(SHAMT_W)) u_field (
                .op    (op_e),
                .sat   (sat_e),
                .a     (a[i*W +: W]),
                .b     (b[i*W +: W]),
                .shamt (shamt),
                .y     (lane_y[gw][i*W +: W])
            );
        end
    end

    simd_mul16 #(.DATA_W(DATA_W)) u_mul (
        .a (a),
        .b (b),
        .y (mul_y)
    );

    simd_pack #(.DATA_W(DATA_W)) u_pack (
        .size (size_e),
        .sat  (sat_e),
        .a    (a),
        .b    (b),
        .y    (pack_y)
    );

    always_comb begin
        if (size_e == SZ_RSV) begin
            next_y = '0;
        end else if (op_e == OP_MUL) begin
            next_y = mul_y;
        end else if (op_e == OP_PACK) begin
            next_y = pack_y;
        end else begin
            unique case (size_e)
                SZ_BYTE: next_y = lane_y[0];
                SZ_HALF: next_y = lane_y[1];
                SZ_WORD: next_y = lane_y[2];
                default: next_y = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_y;
            end
        end
    end

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  op,
    input logic [1:0]  size,
    input logic [63:0] a,
    input logic [63:0] b,
    input logic        out_valid,
    input logic [63:0] result
);

    function automatic logic masks_ok(input logic [63:0] r, input logic [1:0] sz);
        int  w;
        logic ok;
        w  = 8 << sz;
        ok = 1'b1;
        for (int j = 0; j < 64; j++) begin
            if (r[j] != r[(j / w) * w]) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R10
    AST_CMP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 4'd9 || op == 4'd10)) |=> masks_ok(result, $past(size))); // R6
    AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd9 && a == b && size != 2'd3) |=> (result == {64{1'b1}})); // R6
    AST_GT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd10 && a == b) |=> (result == 64'd0)); // R7
    AST_XOR_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd8 && a == b) |=> (result == 64'd0)); // R5
    AST_ANDN_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd6) |=> ((result & $past(a)) == 64'd0)); // R5
    AST_RSV_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == 2'd3) |=> (result == 64'd0)); // R11

endmodule

bind simd_alu simd_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .size      (size),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/simd_alu_bench.sv
module simd_alu_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [1:0]  sat_i = '0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [5:0]  shamt_i = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_exp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_alu u_simd_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op_i),
        .size      (size_i),
        .sat       (sat_i),
        .a         (a_i),
        .b         (b_i),
        .shamt     (shamt_i),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic longint clamp(input longint x, input longint lo, input longint hi);
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

    function automatic logic [63:0] model(input int op, input int sz, input int sat,
                                          input logic [63:0] a, input logic [63:0] b,
                                          input int sh);
        logic [63:0] r;
        int w, nw;
        longint m, nm, ua, ub, sa, sb, v, half;
        r = '0;
        if (sz == 3) return r;
        if (op == 11) begin
            for (int i = 0; i < 4; i++) begin
                ua = longint'(a[i*16 +: 16]);
                ub = longint'(b[i*16 +: 16]);
                r[i*16 +: 16] = 16'((ua * ub) & 64'hFFFF);
            end
            return r;
        end
        if (op == 12) begin
            if (sz == 0) return r;
            w  = 8 << sz;
            nw = w / 2;
            m  = (longint'(1) << w) - 1;
            nm = (longint'(1) << nw) - 1;
            half = longint'(1) << (nw - 1);
            for (int s = 0; s < 2; s++) begin
                for (int i = 0; i < 64 / w; i++) begin
                    ua = longint'(((s == 0) ? a : b) >> (i * w)) & m;
                    sa = (ua >= (longint'(1) << (w - 1))) ? ua - (longint'(1) << w) : ua;
                    if (sat == 1)      v = clamp(sa, -half, half - 1);
                    else if (sat == 2) v = clamp(sa, 0, nm);
                    else               v = sa;
                    r = r | (64'(v & nm) << (s * 32 + i * nw));
                end
            end
            return r;
        end
        if (op > 10) return r;
        w    = 8 << sz;
        m    = (longint'(1) << w) - 1;
        half = longint'(1) << (w - 1);
        for (int i = 0; i < 64 / w; i++) begin
            ua = longint'(a >> (i * w)) & m;
            ub = longint'(b >> (i * w)) & m;
            sa = (ua >= half) ? ua - (longint'(1) << w) : ua;
            sb = (ub >= half) ? ub - (longint'(1) << w) : ub;
            case (op)
                0: v = (sat == 1) ? clamp(sa + sb, -half, half - 1) :
                       (sat == 2) ? clamp(ua + ub, 0, m) : ua + ub;
                1: v = (sat == 1) ? clamp(sa - sb, -half, half - 1) :
                       (sat == 2) ? clamp(ua - ub, 0, m) : ua - ub;
                2: v = (sh >= w) ? 0 : (ua << sh);
                3: v = (sh >= w) ? 0 : (ua >> sh);
                4: v = (sh >= w) ? ((sa < 0) ? -1 : 0) : (sa >>> sh);
                5: v = ua & ub;
                6: v = ~ua & ub;
                7: v = ua | ub;
                8: v = ua ^ ub;
                9: v = (ua == ub) ? -1 : 0;
                10: v = (sa > sb) ? -1 : 0;
                default: v = 0;
            endcase
            r = r | (64'(v & m) << (i * w));
        end
        return r;
    endfunction

    function automatic logic [63:0] pat(input int k);
        case (k % 6)
            0: return 64'h7F01_80FF_0123_FEDC;
            1: return 64'h0101_8001_7FFF_8000;
            2: return 64'hFFFF_FFFF_0000_0001;
            3: return 64'h8000_0000_7FFF_FFFF;
            4: return 64'h00FF_7F80_FF00_0100;
            default: return 64'h8080_7F7F_0001_FFFE;
        endcase
    endfunction

    task automatic send(input int op, input int sz, input int sat,
                        input logic [63:0] ta, input logic [63:0] tb, input int sh,
                        input logic [63:0] exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op_i     = 4'(op);
        size_i   = 2'(sz);
        sat_i    = 2'(sat);
        a_i      = ta;
        b_i      = tb;
        shamt_i  = 6'(sh);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        last_exp = exp;
    endtask

    task automatic send_m(input int op, input int sz, input int sat,
                          input logic [63:0] ta, input logic [63:0] tb, input int sh,
                          input string tag);
        send(op, sz, sat, ta, tb, sh, model(op, sz, sat, ta, tb, sh), tag);
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] got,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Scoreboard monitor: compares each produced result with the queued expectation
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected out_valid", result, 64'd0);
            end else begin
                logic [63:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(result === e, t, result, e);
            end
        end
    end

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog expired got=%h exp=%h", 64'd0, 64'd1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(result === 64'd0, "R10 reset result", result, 64'd0);
        check(out_valid === 1'b0, "R10 reset out_valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;

        // R1 carry isolation, literal
        send(0, 0, 0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 0,
             64'h0, "R1 byte carry isolation");
        // R2 literal signed clamp
        send(0, 0, 1, 64'h0000_0000_0000_007F, 64'h0000_0000_0000_0001, 0,
             64'h0000_0000_0000_007F, "R2 byte positive clamp");
        // R3 literal unsigned floor
        send(1, 1, 2, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 0,
             64'h0, "R3 half zero floor");

        // R1 R2 R3 add and subtract across sizes, modes and patterns
        for (int op = 0; op < 2; op++)
            for (int sz = 0; sz < 3; sz++)
                for (int sat = 0; sat < 4; sat++)
                    for (int k = 0; k < 6; k++)
                        send_m(op, sz, sat, pat(k), pat(k + 1), 0,
                               (sat == 1) ? "R2 signed sat" :
                               (sat == 2) ? "R3 unsigned sat" : "R1 wrap");

        // R4 shifts with counts around the field width
        for (int op = 2; op < 5; op++)
            for (int sz = 0; sz < 3; sz++) begin
                int w;
                w = 8 << sz;
                send_m(op, sz, 0, pat(0), 64'd0, 0, "R4 shift by zero");
                send_m(op, sz, 0, pat(3), 64'd0, 3, "R4 shift by three");
                send_m(op, sz, 0, pat(5), 64'd0, w - 1, "R4 shift width minus one");
                send_m(op, sz, 0, pat(3), 64'd0, w, "R4 shift by width");
                send_m(op, sz, 0, pat(5), 64'd0, 63, "R4 shift by max");
            end
        send(4, 0, 0, 64'h0000_0000_0000_8070, 64'd0, 8,
             64'h0000_0000_0000_FF00, "R4 sra sign fill literal");

        // R5 bitwise, size independent
        for (int op = 5; op < 9; op++)
            for (int sz = 0; sz < 3; sz++)
                send(op, sz, 0, pat(0), pat(2), 0, model(op, 0, 0, pat(0), pat(2), 0),
                     "R5 bitwise");

        // R6 R7 compares
        for (int sz = 0; sz < 3; sz++) begin
            send_m(9, sz, 0, pat(0), 64'h7F01_80FF_0000_FEDD, 0, "R6 compare equal");
            send_m(9, sz, 0, pat(4), pat(4), 0, "R6 compare equal all");
            send_m(10, sz, 0, pat(1), pat(5), 0, "R7 compare greater signed");
            send_m(10, sz, 0, pat(3), pat(2), 0, "R7 compare greater signed");
        end
        send(10, 0, 0, 64'h0000_0000_0000_0180, 64'h0000_0000_0000_FF7F, 0,
             64'h0000_0000_0000_FF00, "R7 greater literal");

        // R8 multiply
        send(11, 1, 0, 64'h0000_0000_0100_0003, 64'h0000_0000_0100_0005, 0,
             64'h0000_0000_0000_000F, "R8 multiply literal");
        for (int sz = 0; sz < 3; sz++)
            send(11, sz, 0, pat(0), pat(5), 0, model(11, 1, 0, pat(0), pat(5), 0),
                 "R8 multiply low half");

        // R9 pack
        send(12, 1, 1, 64'hFFFF_0005_FF00_0100, 64'd0, 0,
             64'h0000_0000_FF05_807F, "R9 pack signed literal");
        for (int sz = 1; sz < 3; sz++)
            for (int sat = 0; sat < 4; sat++)
                for (int k = 0; k < 6; k += 2)
                    send_m(12, sz, sat, pat(k), pat(k + 3), 0, "R9 pack narrowing");

        // R11 reserved codes
        send(0, 3, 0, pat(0), pat(1), 0, 64'd0, "R11 reserved size");
        send(11, 3, 0, pat(0), pat(1), 0, 64'd0, "R11 reserved size multiply");
        send(13, 0, 0, pat(0), pat(1), 0, 64'd0, "R11 reserved opcode 13");
        send(15, 2, 0, pat(0), pat(1), 0, 64'd0, "R11 reserved opcode 15");
        send(12, 0, 1, pat(0), pat(1), 0, 64'd0, "R11 pack with byte size");

        // R10 hold while idle
        send(8, 0, 0, pat(0), pat(1), 0, pat(0) ^ pat(1), "R10 last before idle");
        @(negedge clk);
        in_valid = 1'b0;
        op_i = 4'd7;
        a_i  = pat(4);
        b_i  = pat(5);
        repeat (3) @(negedge clk);
        check(result === last_exp, "R10 result held while idle", result, last_exp);
        check(out_valid === 1'b0, "R10 out_valid low while idle", {63'd0, out_valid}, 64'd0);
        check(exp_q.size() == 0, "R10 all results delivered", 64'(exp_q.size()), 64'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule